// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is a general-purpose I/O controller for eight pins, attached to a simple 16-bit register bus. Each pin can be set to drive a level or to sample one. Software picks the direction of each pin, sets the level that output pins drive, and reads the level of input pins. The pad logic outside the block uses the output-enable and data outputs to build a tri-state buffer.

Any input pin can be made an interrupt source. The pin's input passes through a two-flop synchronizer. After that, a change of level in either direction on an enabled input pin latches a flag for that pin. All flags are ORed into one interrupt request. Software reads the flag register to find the pins that changed, and that read clears the flags. If a new change arrives in the same cycle as the read, its flag is kept.

Register map, by the 2-bit word address: 0 is direction, 1 is data, 2 is interrupt enable (write-only), 3 is flags (read-only, cleared when read). Pin n is held in bit n of each register.

Top module: `gpio_edge_port`

## Requirements
- R1: During reset and after it, every pin is an input. pin_oe is 0 and irq is 0. The direction, enable and flag registers read as 0.
- R2: Writing address 0 sets the direction. A bit of 1 makes that pin an output, so its pin_oe bit is 1. A bit of 0 makes it an input. Reading address 0 returns the value written.
- R3: Writing address 1 changes the driven value (pin_out) only in the bits of pins that are outputs. Bits of input pins keep their old value.
- R4: Reading address 1 returns, in bit n, the driven value when pin n is an output. When pin n is an input, bit n is the level of pin_in n after a two-flop synchronizer. A level change is visible on the second rising edge after it arrives.
- R5: Writing address 2 sets the interrupt-enable bits. Reading address 2 always returns 0.
- R6: A pin's flag is set when the pin is an input, its enable bit is 1, and its synchronized level changes in either direction. The flag is set on the third rising edge after the change arrives at pin_in. Output pins and disabled pins never set a flag.
- R7: irq is 1 exactly when at least one flag is set. Once set, a flag stays set until software clears it.
- R8: Reading address 3 returns the current flags. The read clears all of them at the clock edge that ends the read.
- R9: A flag whose edge is detected in the same cycle as a read of address 3 is not cleared by that read. The read returns the flags as they were before that edge, and the next read returns the new flag.
- R10: Read data bits 15..8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_i | input | 1 | Selects the block for an access this cycle |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; a read of the flag register clears it at the clock edge |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data; combinational, valid while the read is selected |
| pin_in_i | input | 8 | Pin levels from the pads, asynchronous |
| pin_out_o | output | 8 | Levels to drive on the pins |
| pin_oe_o | output | 8 | Output enable for each pin; 1 drives the pin |
| irq_o | output | 1 | Interrupt request; the OR of all flags |

## Verification
The bench uses the default configuration: eight pins, a 16-bit bus and two synchronizer stages. With only eight pins, every one of the 256 direction masks can be swept through the masked data write and the mixed read of address 1. In two enable and direction setups, every one of the 255 non-zero toggle patterns can be applied to the pins, so both edge directions reach every pin. The bench also times a pin change so that its edge lands in the same cycle as a flag read, which tests whether that flag is kept.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_IEN  = 2'd2,
    REG_FLAG = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign rst_no = stg_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] async_i,
  output logic [NPINS-1:0] sync_o
);
  logic [STAGES-1:0][NPINS-1:0] stg_q;
  logic [STAGES-1:0][NPINS-1:0] stg_d;

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_we_i,
  input  logic             data_we_i,
  input  logic             ien_we_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] ien_o
);
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] ien_q, ien_d;

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    ien_d = ien_q;
    if (dir_we_i)  dir_d = wdata_i;
    if (data_we_i) out_d = (out_q & ~dir_q) | (wdata_i & dir_q);
    if (ien_we_i)  ien_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else begin
      if (dir_we_i)  dir_q <= dir_d;
      if (data_we_i) out_q <= out_d;
      if (ien_we_i)  ien_q <= ien_d;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] ien_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] event_o,
  output logic [NPINS-1:0] flag_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] flag_q, flag_d;
  logic [NPINS-1:0] arm;

  always_comb begin
    arm     = ien_i & ~dir_i;
    event_o = (sync_i ^ prev_q) & arm;
    flag_d  = (clr_i ? '0 : flag_q) | event_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= sync_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int NPINS       = 8,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NPINS-1:0] pin_in_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  import gpio_pkg::*;

  localparam int PADW = DW - NPINS;

  logic             rst_n_s;
  logic             wr_en, rd_en;
  logic             dir_we, data_we, ien_we, flag_rd;
  logic [NPINS-1:0] dir_q, out_q, ien_q, sync_v, flag_q, new_ev;
  logic [NPINS-1:0] rd_bits;
  gpio_reg_e        addr;

  assign addr    = gpio_reg_e'(bus_addr_i);
  assign wr_en   = bus_sel_i & bus_wr_i;
  assign rd_en   = bus_sel_i & bus_rd_i;
  assign dir_we  = wr_en & (addr == REG_DIR);
  assign data_we = wr_en & (addr == REG_DATA);
  assign ien_we  = wr_en & (addr == REG_IEN);
  assign flag_rd = rd_en & (addr == REG_FLAG);

  gpio_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .async_i (pin_in_i),
    .sync_o  (sync_v)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .dir_we_i  (dir_we),
    .data_we_i (data_we),
    .ien_we_i  (ien_we),
    .wdata_i   (bus_wdata_i[NPINS-1:0]),
    .dir_o     (dir_q),
    .out_o     (out_q),
    .ien_o     (ien_q)
  );

  gpio_edge_flags #(.NPINS(NPINS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .sync_i  (sync_v),
    .dir_i   (dir_q),
    .ien_i   (ien_q),
    .clr_i   (flag_rd),
    .event_o (new_ev),
    .flag_o  (flag_q)
  );

  always_comb begin
    rd_bits = '0;
    if (rd_en) begin
      unique case (addr)
        REG_DIR:  rd_bits = dir_q;
        REG_DATA: rd_bits = (dir_q & out_q) | (~dir_q & sync_v);
        REG_IEN:  rd_bits = '0;
        REG_FLAG: rd_bits = flag_q;
        default:  rd_bits = '0;
      endcase
    end
  end

  generate
    if (PADW > 0) begin : g_pad
      assign bus_rdata_o = {{PADW{1'b0}}, rd_bits};
    end else begin : g_nopad
      assign bus_rdata_o = rd_bits;
    end
  endgenerate

  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q;
  assign irq_o     = |flag_q;
endmodule

module gpio_edge_port_chk #(
  parameter int NPINS = 8,
  parameter int DW    = 16
) (
  input logic             clk_i,
  input logic             rst_n_s,
  input logic             data_we,
  input logic             flag_rd,
  input logic [NPINS-1:0] new_ev,
  input logic [NPINS-1:0] flag_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] pin_out_o,
  input logic [NPINS-1:0] pin_oe_o,
  input logic [DW-1:0]    bus_rdata_o,
  input logic             irq_o
);
  localparam logic [DW-1:0] LOWMASK = DW'((1 << NPINS) - 1);

  // R3
  data_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    data_we |=> ((pin_out_o & ~$past(pin_oe_o)) == ($past(pin_out_o) & ~$past(pin_oe_o))));

  // R6
  flag_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~($past(ien_q) & ~$past(dir_q))) == '0));

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (irq_o && !flag_rd) |=> irq_o);

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (flag_rd && new_ev == '0) |=> !irq_o);

  // R9
  keep_new_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (flag_rd && new_ev != '0) |=> irq_o);

  // R10
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (bus_rdata_o & ~LOWMASK) == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_n_s     (rst_n_s),
  .data_we     (data_we),
  .flag_rd     (flag_rd),
  .new_ev      (new_ev),
  .flag_q      (flag_q),
  .dir_q       (dir_q),
  .ien_q       (ien_q),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic [7:0]  pin_in = 8'd0;
  logic [7:0]  pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; the write is taken at the next rising edge
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edge_sweep(input logic [7:0] dir, input logic [7:0] ien);
    logic [15:0] v;
    logic [7:0]  exp;
    wr_reg(2'd0, {8'h00, dir});
    wr_reg(2'd2, {8'h00, ien});
    idle(4);
    rd_reg(2'd3, v);
    for (int t = 1; t < 256; t++) begin
      pin_in = pin_in ^ t[7:0];
      idle(4);
      exp = t[7:0] & ien & ~dir;
      check("R7 irq", {15'd0, irq}, {15'd0, (exp != 8'd0)});
      rd_reg(2'd3, v);
      check("R6 flags", v, {8'h00, exp});
      check("R8 irq cleared", {15'd0, irq}, 16'd0);
      rd_reg(2'd3, v);
      check("R8 flags cleared", v, 16'd0);
    end
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  p;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {8'h00, pin_oe}, 16'd0);
    check("R1 irq in reset", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    idle(4);
    rd_reg(2'd0, v); check("R1 dir after reset", v, 16'd0);
    rd_reg(2'd2, v); check("R1 ien after reset", v, 16'd0);
    rd_reg(2'd3, v); check("R1 flag after reset", v, 16'd0);
    check("R1 oe after reset", {8'h00, pin_oe}, 16'd0);

    for (int d = 0; d < 256; d++) begin
      p = 8'(d * 37 + 91);
      wr_reg(2'd0, 16'hFFFF);
      wr_reg(2'd1, 16'h0000);
      wr_reg(2'd0, {8'hA5, d[7:0]});
      check("R2 oe", {8'h00, pin_oe}, {8'h00, d[7:0]});
      rd_reg(2'd0, v); check("R2 dir readback", v, {8'h00, d[7:0]});
      wr_reg(2'd1, 16'hFFFF);
      check("R3 masked write", {8'h00, pin_out}, {8'h00, d[7:0]});
      pin_in = p;
      idle(2);
      rd_reg(2'd1, v);
      check("R4 data read", v, {8'h00, d[7:0] | (~d[7:0] & p)});
      check("R10 upper zero", v & 16'hFF00, 16'd0);
    end

    wr_reg(2'd0, 16'h0000);
    pin_in = 8'h00;
    idle(4);
    pin_in = 8'h3C;
    @(negedge clk);
    rd_reg(2'd1, v); check("R4 before sync", v, 16'h0000);
    rd_reg(2'd1, v); check("R4 after sync", v, 16'h003C);

    wr_reg(2'd2, 16'hFFFF);
    rd_reg(2'd2, v); check("R5 ien reads zero", v, 16'd0);

    edge_sweep(8'h00, 8'hFF);
    edge_sweep(8'h0C, 8'hA5);

    // R9: edge reaches flag in the same cycle as a read
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd2, 16'h00FF);
    idle(4);
    rd_reg(2'd3, v);
    pin_in = pin_in ^ 8'h01;
    idle(4);
    pin_in = pin_in ^ 8'h02;
    idle(2);
    rd_reg(2'd3, v); check("R9 read sees old", v, 16'h0001);
    check("R9 irq kept", {15'd0, irq}, 16'd1);
    rd_reg(2'd3, v); check("R9 new flag kept", v, 16'h0002);
    check("R8 irq clear", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule